// File: doc/BRIEF.md
# Prioritized dual-bank interrupt controller

This block collects up to 32 interrupt inputs and presents them to a processor as two independent request lines: a normal request line and a fast request line. Every input first passes through a per-input polarity stage and an optional latch stage. The latch holds a short pulse until software acknowledges it. Two banks then look at the same conditioned inputs. Each bank has its own mask and its own priority threshold, and each drives one output line.

Every input has a 4-bit priority, where 0 is the most urgent. Polarity, latch mode and priority are shared by both banks. A bank reports a summary of its pending inputs and the index of its most urgent pending input. Reading the bank's acknowledge register returns that index and clears the input's latch. An interrupt handler therefore reads the summary, reads the acknowledge register to learn which input to serve, and repeats until the summary is zero.

Access is through a plain 32-bit register bus. Each cycle in which `bus_wr_i` is high performs one write. Each cycle in which `bus_rd_i` is high performs one read. Read data is combinational and valid in the same cycle as the read strobe.

Top module: `dual_bank_intc`

## Requirements
- R1: The normal bank sits at base 0x000 and the fast bank at base 0x100, with the same layout in each. Within a bank: pending summary +0x00, conditioned inputs +0x04, mask set +0x08, mask clear +0x0C, winner index +0x20, acknowledge +0x28, threshold +0x2C. Polarity is at 0x200, latch select at 0x204, and the priority of input i at 0x300+4*i. Any other address reads 0, including addresses whose bits [1:0] are not 00.
- R2: A write to +0x08 sets every mask bit whose data bit is 1. A write to +0x0C clears every mask bit whose data bit is 1. Data bits that are 0 leave the mask unchanged. Reading +0x08 returns the mask, and reading +0x0C returns 0.
- R3: The conditioned input equals the input pin when its polarity bit (0x200) is 1, and the inverted pin when the bit is 0.
- R4: When an input's latch bit (0x204) is 0, its conditioned state follows the pin one clock later. When the latch bit is 1, the state is set on any clock at which the conditioned pin is 1. It then stays set until that input is acknowledged while its conditioned pin is 0. Reading +0x04 returns these states, whatever the mask or threshold.
- R5: The priority registers hold 4 bits and read back zero-extended. An input is pending in a bank only if its state is 1, its mask bit in that bank is 1, and its priority is less than or equal to the bank's threshold (+0x2C, 4 bits).
- R6: Reading +0x00 returns the bank's pending vector. `irq_o` is high exactly when the normal bank's pending vector is nonzero, and `fiq_o` is high exactly when the fast bank's pending vector is nonzero.
- R7: Reading +0x20 returns the index of the pending input with the smallest priority value. When several inputs share that value, the lowest index wins. The register reads 0 when nothing is pending.
- R8: A read of +0x28 returns the same index as +0x20. When the bank has an input pending, the clock edge that ends the read clears that input's latched state. The latch of every other input is kept. When nothing is pending, the read has no effect.
- R9: After reset both masks are 0, both thresholds are 0xF, polarity is all ones, latch select is all zeros, every priority is 0 and every state is 0.
- R10: Writes to read-only or unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt input pins |
| bus_addr_i | input | 12 | Byte address |
| bus_wr_i | input | 1 | Write strobe, one write per high cycle |
| bus_rd_i | input | 1 | Read strobe, one read per high cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while `bus_rd_i` is high |
| irq_o | output | 1 | Normal bank request |
| fiq_o | output | 1 | Fast bank request |

## Verification
The bench targets several corner cases:
- **Tie between equal priorities.** A tie broken toward the higher index would show up as the wrong winner index.
- **Threshold equal to an input's priority.** A strict comparison would drop that input from the summary and lower the output line.
- **Acknowledge of a latched input after its pin has fallen.** If the latch were not cleared, the request line would stay high. If the wrong input were cleared, the other input's latch would be lost.
- **Acknowledge with nothing pending, and mask writes with mixed zero and one bits.** A design that cleared index 0 on an empty acknowledge, or that treated a write as a plain load, would diverge from the reference model within a cycle.

A long random phase with inverted polarities and mixed latch modes then runs against the model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  // offsets inside a bank window
  localparam logic [7:0] OFS_PEND   = 8'h00;
  localparam logic [7:0] OFS_STATE  = 8'h04;
  localparam logic [7:0] OFS_SET    = 8'h08;
  localparam logic [7:0] OFS_CLR    = 8'h0C;
  localparam logic [7:0] OFS_WIN    = 8'h20;
  localparam logic [7:0] OFS_ACK    = 8'h28;
  localparam logic [7:0] OFS_THR    = 8'h2C;

  localparam logic [ADDR_W-1:0] POL_ADDR   = 12'h200;
  localparam logic [ADDR_W-1:0] LATCH_ADDR = 12'h204;
  localparam logic [3:0]        PRIO_PAGE  = 4'h3;
  localparam logic [ADDR_W-1:0] PRIO_BASE  = 12'h300;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/intc_src_cond.sv
module intc_src_cond #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] latch_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] state_o
);
  logic [NUM_SRC-1:0] cond;

  assign cond = src_i ~^ pol_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_o[g] <= 1'b0;
      end else if (latch_i[g]) begin
        state_o[g] <= cond[g] | (state_o[g] & ~clr_i[g]);
      end else begin
        state_o[g] <= cond[g];
      end
    end
  end
endmodule

// File: rtl/intc_shared_regs.sv
module intc_shared_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_SRC-1:0]              pol_o,
  output logic [NUM_SRC-1:0]              latch_o,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o   <= '1;
      latch_o <= '0;
    end else if (wr_i) begin
      if (addr_i == POL_ADDR)   pol_o   <= wdata_i[NUM_SRC-1:0];
      if (addr_i == LATCH_ADDR) latch_o <= wdata_i[NUM_SRC-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_prio
    localparam logic [ADDR_W-1:0] MY_ADDR = PRIO_BASE + ADDR_W'(4 * g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[g] <= '0;
      end else if (wr_i && addr_i == MY_ADDR) begin
        prio_o[g] <= wdata_i[PRIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]               win_o,
  output logic                           any_o
);
  logic [PRIO_W-1:0] best;
  logic              found;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best  = '1;
    found = 1'b0;
    win_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!found || prio_i[i] < best)) begin
        found = 1'b1;
        best  = prio_i[i];
        win_o = IDX_W'(i);
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             state_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                           set_we_i,
  input  logic                           clr_we_i,
  input  logic                           thr_we_i,
  input  logic [NUM_SRC-1:0]             wdata_i,
  output logic [NUM_SRC-1:0]             mask_o,
  output logic [PRIO_W-1:0]              thr_o,
  output logic [NUM_SRC-1:0]             pend_o,
  output logic [IDX_W-1:0]               win_o,
  output logic                           any_o
);
  logic [NUM_SRC-1:0] in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
    end else if (set_we_i) begin
      mask_o <= mask_o | wdata_i;
    end else if (clr_we_i) begin
      mask_o <= mask_o & ~wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_o <= '1;
    else if (thr_we_i) thr_o <= wdata_i[PRIO_W-1:0];
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_rng
    assign in_range[g] = (prio_i[g] <= thr_o);
  end

  assign pend_o = state_i & mask_o & in_range;

  intc_arbiter #(
    .NUM_SRC(NUM_SRC),
    .PRIO_W (PRIO_W)
  ) u_arb (
    .pend_i(pend_o),
    .prio_i(prio_i),
    .win_o (win_o),
    .any_o (any_o)
  );
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       src_i,
  input  logic [11:0]       bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [NUM_SRC-1:0]                    pol_q, latch_q, raw_w, ack_clr;
  logic [NUM_SRC-1:0][PRIO_W-1:0]        prio_q;
  logic [NUM_BANKS-1:0][NUM_SRC-1:0]     mask_w, pend_w;
  logic [NUM_BANKS-1:0][PRIO_W-1:0]      thr_w;
  logic [NUM_BANKS-1:0][IDX_W-1:0]       cur_w;
  logic [NUM_BANKS-1:0]                  any_w, ack_w;
  logic [7:0]                            ofs;

  assign ofs = bus_addr_i[7:0];

  intc_shared_regs #(
    .NUM_SRC(NUM_SRC),
    .PRIO_W (PRIO_W)
  ) u_shared (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (bus_wr_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .pol_o  (pol_q),
    .latch_o(latch_q),
    .prio_o (prio_q)
  );

  intc_src_cond #(
    .NUM_SRC(NUM_SRC)
  ) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i[NUM_SRC-1:0]),
    .pol_i  (pol_q),
    .latch_i(latch_q),
    .clr_i  (ack_clr),
    .state_o(raw_w)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [3:0] PAGE = 4'(b);
    logic set_we, clr_we, thr_we;

    assign set_we   = bus_wr_i && bus_addr_i == {PAGE, OFS_SET};
    assign clr_we   = bus_wr_i && bus_addr_i == {PAGE, OFS_CLR};
    assign thr_we   = bus_wr_i && bus_addr_i == {PAGE, OFS_THR};
    assign ack_w[b] = bus_rd_i && bus_addr_i == {PAGE, OFS_ACK} && any_w[b];

    intc_bank #(
      .NUM_SRC(NUM_SRC),
      .PRIO_W (PRIO_W)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .state_i (raw_w),
      .prio_i  (prio_q),
      .set_we_i(set_we),
      .clr_we_i(clr_we),
      .thr_we_i(thr_we),
      .wdata_i (bus_wdata_i[NUM_SRC-1:0]),
      .mask_o  (mask_w[b]),
      .thr_o   (thr_w[b]),
      .pend_o  (pend_w[b]),
      .win_o   (cur_w[b]),
      .any_o   (any_w[b])
    );
  end

  always_comb begin
    ack_clr = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ack_w[b]) ack_clr[cur_w[b]] = 1'b1;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr_i[11:8] == 4'(b)) begin
        case (ofs)
          OFS_PEND:         bus_rdata_o = 32'(pend_w[b]);
          OFS_STATE:        bus_rdata_o = 32'(raw_w);
          OFS_SET:          bus_rdata_o = 32'(mask_w[b]);
          OFS_WIN, OFS_ACK: bus_rdata_o = 32'(cur_w[b]);
          OFS_THR:          bus_rdata_o = 32'(thr_w[b]);
          default:          bus_rdata_o = '0;
        endcase
      end
    end
    if (bus_addr_i == POL_ADDR)   bus_rdata_o = 32'(pol_q);
    if (bus_addr_i == LATCH_ADDR) bus_rdata_o = 32'(latch_q);
    if (bus_addr_i[11:8] == PRIO_PAGE && bus_addr_i[1:0] == 2'b00 &&
        bus_addr_i[7:2] < 6'(NUM_SRC))
      bus_rdata_o = 32'(prio_q[bus_addr_i[2+:IDX_W]]);
  end

  assign irq_o = any_w[0];
  assign fiq_o = any_w[1];
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [31:0]               src_i,
  input logic [11:0]               bus_addr_i,
  input logic                      bus_wr_i,
  input logic                      bus_rd_i,
  input logic [31:0]               bus_wdata_i,
  input logic                      irq_o,
  input logic                      fiq_o,
  input logic [NUM_SRC-1:0]        pol_q,
  input logic [NUM_SRC-1:0]        latch_q,
  input logic [NUM_SRC-1:0]        raw_w,
  input logic [1:0][NUM_SRC-1:0]   mask_w,
  input logic [1:0][NUM_SRC-1:0]   pend_w,
  input logic [1:0][IDX_W-1:0]     cur_w,
  input logic [1:0]                any_w
);
  // R2
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 12'h008 |=>
      (mask_w[0] & $past(bus_wdata_i[NUM_SRC-1:0])) == $past(bus_wdata_i[NUM_SRC-1:0]));

  // R2
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i && bus_addr_i == 12'h10C |=>
      (mask_w[1] & $past(bus_wdata_i[NUM_SRC-1:0])) == '0);

  // R4
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_w ^ $past(src_i[NUM_SRC-1:0] ~^ pol_q)) & $past(~latch_q)) == '0);

  // R6
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_w[0] == '0 |-> !irq_o);

  // R7
  irq_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_w[0][cur_w[0]]);

  // R7
  fiq_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> pend_w[1][cur_w[1]]);

  // R8
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && bus_addr_i == 12'h028 && any_w[0] && latch_q[cur_w[0]] &&
    (src_i[cur_w[0]] != pol_q[cur_w[0]]) |=> !raw_w[$past(cur_w[0])]);
endmodule

bind dual_bank_intc dual_bank_intc_chk #(
  .NUM_SRC(NUM_SRC),
  .PRIO_W (PRIO_W)
) u_chk (.*);

// File: tb/dual_bank_intc_bench.sv
`timescale 1ns/1ps
module dual_bank_intc_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic [11:0] bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, fiq_o;

  always #4 clk_i = ~clk_i;

  dual_bank_intc u_dual_bank_intc (.*);

  // reference state
  logic [31:0] m_mask [2];
  logic [3:0]  m_thr  [2];
  logic [31:0] m_pol, m_stk, m_raw;
  int          m_prio [32];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  function automatic logic [31:0] m_pend(int b);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (m_raw[i] && m_mask[b][i] && m_prio[i] <= int'(m_thr[b])) r[i] = 1'b1;
    return r;
  endfunction

  function automatic int m_win(int b);
    logic [31:0] p = m_pend(b);
    int best = 99;
    int idx = 0;
    for (int i = 0; i < 32; i++)
      if (p[i] && m_prio[i] < best) begin best = m_prio[i]; idx = i; end
    return idx;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    int b;
    if (a == 12'h200) return m_pol;
    if (a == 12'h204) return m_stk;
    if (a >= 12'h300 && a < 12'h380 && a[1:0] == 2'b00) return 32'(m_prio[(a - 12'h300) / 4]);
    if (a[11:8] > 4'h1) return '0;
    b = int'(a[11:8]);
    case (a[7:0])
      8'h00: return m_pend(b);
      8'h04: return m_raw;
      8'h08: return m_mask[b];
      8'h20, 8'h28: return 32'(m_win(b));
      8'h2C: return 32'(m_thr[b]);
      default: return '0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(string tag, logic [31:0] src, bit wr, bit rd, logic [11:0] a, logic [31:0] wd);
    logic [31:0] clr, cond, exp;
    src_i = src; bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = wd;
    #1;
    // R6 line checks every cycle
    check(irq_o == (m_pend(0) != 0), "R6 irq_o", 32'(irq_o), 32'(m_pend(0) != 0));
    check(fiq_o == (m_pend(1) != 0), "R6 fiq_o", 32'(fiq_o), 32'(m_pend(1) != 0));
    if (rd) begin
      exp = m_read(a);
      check(bus_rdata_o == exp, tag, bus_rdata_o, exp);
    end
    @(posedge clk_i);
    clr = '0;
    if (rd) for (int b = 0; b < 2; b++)
      if (a == 12'(b * 256 + 'h28) && m_pend(b) != 0) clr[m_win(b)] = 1'b1;
    cond = src ~^ m_pol;
    m_raw = (m_stk & (cond | (m_raw & ~clr))) | (~m_stk & cond);
    if (wr) begin
      for (int b = 0; b < 2; b++) begin
        if (a == 12'(b * 256 + 'h08)) m_mask[b] = m_mask[b] | wd;
        if (a == 12'(b * 256 + 'h0C)) m_mask[b] = m_mask[b] & ~wd;
        if (a == 12'(b * 256 + 'h2C)) m_thr[b] = wd[3:0];
      end
      if (a == 12'h200) m_pol = wd;
      if (a == 12'h204) m_stk = wd;
      if (a >= 12'h300 && a < 12'h380 && a[1:0] == 2'b00) m_prio[(a - 12'h300) / 4] = int'(wd[3:0]);
    end
    @(negedge clk_i);
  endtask

  task automatic rd(string tag, logic [31:0] src, logic [11:0] a);
    cyc(tag, src, 1'b0, 1'b1, a, '0);
  endtask

  task automatic wr(logic [31:0] src, logic [11:0] a, logic [31:0] d);
    cyc("R6", src, 1'b1, 1'b0, a, d);
  endtask

  function automatic logic [11:0] pick_addr(int k);
    case (k % 14)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;  3: return 12'h00C;
      4: return 12'h020;  5: return 12'h028;  6: return 12'h02C;  7: return 12'h100;
      8: return 12'h108;  9: return 12'h10C; 10: return 12'h128; 11: return 12'h12C;
      12: return 12'h204;
      default: return 12'h300 + 12'(4 * ($urandom % 32));
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] s;
    m_mask[0] = '0; m_mask[1] = '0; m_thr[0] = 4'hF; m_thr[1] = 4'hF;
    m_pol = '1; m_stk = '0; m_raw = '0;
    for (int i = 0; i < 32; i++) m_prio[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 reset values
    rd("R9 mask0", 0, 12'h008);   rd("R9 mask1", 0, 12'h108);
    rd("R9 thr0", 0, 12'h02C);    rd("R9 thr1", 0, 12'h12C);
    rd("R9 pol", 0, 12'h200);     rd("R9 latch", 0, 12'h204);
    rd("R9 prio31", 0, 12'h37C);  rd("R9 win", 0, 12'h020);
    rd("R9 state", 0, 12'h004);

    // R2 set/clear with mixed bits
    wr(0, 12'h008, 32'h0000_00F0);
    rd("R2 set", 0, 12'h008);
    wr(0, 12'h00C, 32'h0000_0030);
    rd("R2 clear", 0, 12'h008);
    rd("R2 clear reads 0", 0, 12'h00C);

    // R6 pending summary
    s = 32'h0000_00D0;
    cyc("R6", s, 0, 0, 0, 0);
    rd("R6 pending", s, 12'h000);
    rd("R4 state", s, 12'h004);

    // R3 polarity inversion
    s = 32'h0;
    wr(s, 12'h200, 32'hFFFF_FFFE);
    wr(s, 12'h008, 32'h1);
    cyc("R3", s, 0, 0, 0, 0);
    rd("R3 inverted pending", s, 12'h000);
    wr(s, 12'h200, 32'hFFFF_FFFF);
    wr(s, 12'h00C, 32'hFFFF_FFFF);

    // R4 latch and R8 acknowledge on fast bank
    wr(s, 12'h204, 32'h0000_0300);
    wr(s, 12'h108, 32'h0000_0300);
    cyc("R4", 32'h0000_0300, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0);
    rd("R4 latched state", 0, 12'h104);
    rd("R4 state ignores mask", 0, 12'h004);
    rd("R8 ack returns win", 0, 12'h128);
    rd("R8 other latch kept", 0, 12'h104);
    rd("R8 second ack", 0, 12'h128);
    rd("R8 all cleared", 0, 12'h104);
    rd("R8 empty ack", 0, 12'h128);
    rd("R8 empty state", 0, 12'h104);

    // R5/R7 priorities, ties and threshold
    wr(0, 12'h314, 32'h3);
    wr(0, 12'h318, 32'h2);
    wr(0, 12'h31C, 32'hF2);
    rd("R5 prio readback", 0, 12'h31C);
    wr(0, 12'h008, 32'h0000_00E0);
    s = 32'h0000_00E0;
    cyc("R7", s, 0, 0, 0, 0);
    rd("R7 tie lowest index", s, 12'h020);
    wr(s, 12'h02C, 32'h2);
    rd("R5 threshold equal kept", s, 12'h000);
    wr(s, 12'h02C, 32'h1);
    rd("R5 threshold drops all", s, 12'h000);
    rd("R7 win empty", s, 12'h020);
    wr(s, 12'h02C, 32'hF);

    // R10 read-only writes ignored, R1 unmapped reads
    wr(s, 12'h000, 32'hFFFF_FFFF);
    wr(s, 12'h020, 32'hFFFF_FFFF);
    wr(s, 12'h202, 32'h0);
    rd("R10 mask unchanged", s, 12'h008);
    rd("R10 pol unchanged", s, 12'h200);
    rd("R1 unmapped 010", s, 12'h010);
    rd("R1 misaligned", s, 12'h202);
    rd("R1 beyond prio", s, 12'h3FC);
    rd("R1 page 4", s, 12'h400);
    rd("R1 fast bank pend", s, 12'h100);

    // random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 8;
      logic [11:0] a = pick_addr($urandom);
      s = $urandom & $urandom;
      if (op < 4) rd("R1 R7 R8 random read", s, a);
      else if (op < 6) wr(s, a, $urandom);
      else if (op == 6) wr(s, 12'h200, ~($urandom & $urandom & $urandom));
      else cyc("R6", s, 0, 0, 0, 0);
    end
    finish_run();
  end
endmodule